// File: doc/BRIEF.md
# Strobed Digital I/O Port with Timer Decode

This block is a slave on a byte-wide peripheral I/O bus. It claims a window of eight consecutive byte addresses whose position is set by a six-bit configuration input. Within the window it offers 32 digital output bits and 32 digital input bits, four bytes each way. The same four offsets serve both directions: a write updates output bits and a read returns input bits. The upper four offsets belong to an external counter block. For these the port produces select, read and write strobes, passes the write data through, and returns the counter's read data on the bus.

The 32 inputs are split into two 16-bit halves, and each half has its own external strobe. While a half's strobe is high, or left open and pulled high, reads of that half follow the pins. When the strobe falls, the half freezes at the value it held just before. It stays frozen until the strobe rises again. Strobes and data pins pass through a two-flop synchronizer before use.

Top module: `dio_port_bridge`

## Requirements
- R1: A read falls inside the window when address bit 9 is 1 and address bits 8:3 equal `cfg_base`. `bus_rvalid` is high in the cycle after a read strobe exactly when that read fell inside the window.
- R2: A write inside the window at offset k (address bits 2:0, k = 0..3) loads `bus_wdata` into `dout[8k+7:8k]` on the next clock edge, with bit 0 the lowest channel. Every other write, in or out of the window, leaves `dout` unchanged.
- R3: A read inside the window at offset k (0..3) returns input channels 8k+7..8k in `bus_rdata` in the following cycle.
- R4: An access inside the window at offset 4, 5 or 6 raises `tmr_sel` bit 0, 1 or 2 respectively in the same cycle, with no other bit set. A read also raises `tmr_rd`, and a write also raises `tmr_wr`. A read returns the value of `tmr_rdata` in the following cycle.
- R5: A write inside the window at offset 7 raises `tmr_ctl` and `tmr_wr` with `tmr_sel` zero. A read at offset 7 returns 0xFF and raises no timer strobe.
- R6: An access outside the window raises no timer strobe. A read outside the window leaves `bus_rvalid` low and `bus_rdata` at 0x00.
- R7: While strobe bit h is high, input half h (channels 16h+15..16h) follows the pins within four clock cycles.
- R8: While strobe bit h is low, input half h holds the value it had when the strobe fell, whatever the pins do. The other half is unaffected.
- R9: After reset, `dout` is all zeros, `bus_rvalid` is low, and both strobes are treated as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 6 | Window base; compared with address bits 8:3 |
| bus_addr | input | 10 | Byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read strobe |
| bus_rvalid | output | 1 | High when `bus_rdata` carries a read inside the window |
| din | input | 32 | Digital input pins |
| din_strobe | input | 2 | Latch strobes; bit 0 gates channels 0-15, bit 1 gates 16-31 |
| dout | output | 32 | Digital output bits |
| tmr_sel | output | 3 | One-hot counter select |
| tmr_ctl | output | 1 | Counter control register write |
| tmr_rd | output | 1 | Counter read strobe |
| tmr_wr | output | 1 | Counter or control write strobe |
| tmr_wdata | output | 8 | Write data passed to the counter block |
| tmr_rdata | input | 8 | Read data from the counter block |

## Verification
The decode is swept over every one of the 1024 addresses, both reading and writing, for several base values including both ends of the range. This separates hits from near misses on each compared bit and on the fixed high bit, and it tells each offset's kind apart. The write sweep uses data derived from the address, so a byte steered to the wrong lane shows up as a mismatch in the output model. The strobe sequence freezes each half in turn, changes the pins while frozen, and then releases. This shows whether the halves are gated independently and whether the captured value is the one present before the fall.

// File: rtl/dio_pkg.sv
package dio_pkg;
    localparam int LANE_W     = 8;
    localparam int N_LANES    = 4;
    localparam int LANE_IDX_W = $clog2(N_LANES);
    localparam int N_CNT      = 3;
    localparam int OFF_W      = 3;

    typedef enum logic [1:0] {
        ACC_DIO = 2'd0,
        ACC_CNT = 2'd1,
        ACC_CTL = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/dio_addr_decode.sv
module dio_addr_decode #(
    parameter int ADDR_W = 10,
    localparam int BASE_W = ADDR_W - 1 - dio_pkg::OFF_W
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [BASE_W-1:0]               cfg_base,
    input  logic                            rd,
    input  logic                            wr,
    output logic                            hit,
    output dio_pkg::acc_kind_e              kind,
    output logic [dio_pkg::LANE_IDX_W-1:0]  lane,
    output logic [dio_pkg::N_CNT-1:0]       tmr_sel,
    output logic                            tmr_ctl,
    output logic                            tmr_rd,
    output logic                            tmr_wr
);
    import dio_pkg::*;

    logic [OFF_W-1:0] off;
    logic             cnt_acc;

    always_comb begin
        off  = addr[OFF_W-1:0];
        hit  = addr[ADDR_W-1] && (addr[ADDR_W-2:OFF_W] == cfg_base);
        lane = off[LANE_IDX_W-1:0];
        if (!off[OFF_W-1])
            kind = ACC_DIO;
        else if (&off)
            kind = ACC_CTL;
        else
            kind = ACC_CNT;
        cnt_acc = hit && (kind == ACC_CNT);
        tmr_rd  = cnt_acc && rd;
        tmr_wr  = hit && (kind != ACC_DIO) && wr;
        tmr_ctl = hit && (kind == ACC_CTL) && wr;
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_sel
        assign tmr_sel[g] = cnt_acc && (rd || wr) && (lane == LANE_IDX_W'(g));
    end
endmodule

// File: rtl/dio_out_regs.sv
module dio_out_regs #(
    parameter int W = 32,
    localparam int N_LN = W / dio_pkg::LANE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [dio_pkg::LANE_IDX_W-1:0] lane,
    input  logic [dio_pkg::LANE_W-1:0]     wdata,
    output logic [W-1:0]                   dout
);
    import dio_pkg::*;

    typedef struct packed {
        logic [W-1:0] bits;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_LN; i++) begin
            if (wr_en && (lane == LANE_IDX_W'(i)))
                st_d.bits[i*LANE_W +: LANE_W] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dout = st_q.bits;

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dout)); // R2
endmodule

// File: rtl/dio_strobe_gate.sv
module dio_strobe_gate #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] pins,
    output logic [W-1:0] view
);
    typedef struct packed {
        logic         stb_meta;
        logic         stb_sync;
        logic [W-1:0] pin_meta;
        logic [W-1:0] pin_sync;
        logic [W-1:0] held;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.stb_meta = strobe;
        st_d.stb_sync = st_q.stb_meta;
        st_d.pin_meta = pins;
        st_d.pin_sync = st_q.pin_meta;
        if (st_q.stb_sync)
            st_d.held = st_q.pin_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.stb_meta <= 1'b1;
            st_q.stb_sync <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign view = st_q.held;

    AST_FREEZE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stb_sync |=> $stable(view)); // R8
    AST_FOLLOW_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stb_sync |=> (view == $past(st_q.pin_sync))); // R7
endmodule

// File: rtl/dio_port_bridge.sv
module dio_port_bridge #(
    parameter int ADDR_W = 10,
    parameter int CH_W   = 32,
    localparam int BASE_W = ADDR_W - 1 - dio_pkg::OFF_W,
    localparam int HALF_W = CH_W / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BASE_W-1:0]           cfg_base,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [dio_pkg::LANE_W-1:0]  bus_wdata,
    output logic [dio_pkg::LANE_W-1:0]  bus_rdata,
    output logic                        bus_rvalid,
    input  logic [CH_W-1:0]             din,
    input  logic [1:0]                  din_strobe,
    output logic [CH_W-1:0]             dout,
    output logic [dio_pkg::N_CNT-1:0]   tmr_sel,
    output logic                        tmr_ctl,
    output logic                        tmr_rd,
    output logic                        tmr_wr,
    output logic [dio_pkg::LANE_W-1:0]  tmr_wdata,
    input  logic [dio_pkg::LANE_W-1:0]  tmr_rdata
);
    import dio_pkg::*;

    typedef struct packed {
        logic [LANE_W-1:0] rdata;
        logic              rvalid;
    } rd_state_t;

    logic                  hit;
    acc_kind_e             kind;
    logic [LANE_IDX_W-1:0] lane;
    logic [CH_W-1:0]       in_word;
    rd_state_t             rs_d, rs_q;

    dio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .cfg_base (cfg_base),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .hit      (hit),
        .kind     (kind),
        .lane     (lane),
        .tmr_sel  (tmr_sel),
        .tmr_ctl  (tmr_ctl),
        .tmr_rd   (tmr_rd),
        .tmr_wr   (tmr_wr)
    );

    dio_out_regs #(.W(CH_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && hit && (kind == ACC_DIO)),
        .lane  (lane),
        .wdata (bus_wdata),
        .dout  (dout)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        dio_strobe_gate #(.W(HALF_W)) u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (din_strobe[h]),
            .pins   (din[h*HALF_W +: HALF_W]),
            .view   (in_word[h*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        rs_d.rvalid = bus_rd && hit;
        rs_d.rdata  = '0;
        if (rs_d.rvalid) begin
            case (kind)
                ACC_DIO: rs_d.rdata = in_word[lane*LANE_W +: LANE_W];
                ACC_CNT: rs_d.rdata = tmr_rdata;
                default: rs_d.rdata = '1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rs_q <= '0;
        else
            rs_q <= rs_d;
    end

    assign bus_rdata  = rs_q.rdata;
    assign bus_rvalid = rs_q.rvalid;
    assign tmr_wdata  = bus_wdata;

    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd)); // R1
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_sel)); // R4
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:OFF_W] == cfg_base))
        |-> (tmr_sel == '0 && !tmr_rd && !tmr_wr && !tmr_ctl)); // R6
    AST_CTL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ctl |-> (bus_wr && tmr_wr && tmr_sel == '0 && !tmr_rd)); // R5
    AST_MISS_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0)); // R6
endmodule

// File: tb/tb_dio_port_bridge.sv
`timescale 1ns/1ps
module tb_dio_port_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_base = '0;
    logic [9:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [31:0] din = '0;
    logic [1:0]  din_strobe = 2'b11;
    logic [31:0] dout;
    logic [2:0]  tmr_sel;
    logic        tmr_ctl, tmr_rd, tmr_wr;
    logic [7:0]  tmr_wdata;
    logic [7:0]  tmr_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] exp_in;
    logic [31:0] dm;

    always #2 clk = ~clk;

    dio_port_bridge dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .din(din),
        .din_strobe(din_strobe), .dout(dout), .tmr_sel(tmr_sel),
        .tmr_ctl(tmr_ctl), .tmr_rd(tmr_rd), .tmr_wr(tmr_wr),
        .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [9:0] a);
        return a[9] && (a[8:3] == cfg_base);
    endfunction

    task automatic do_read(input logic [9:0] a, input string dio_tag);
        bit       h;
        logic [2:0] off;
        logic [7:0] exp_d;
        @(negedge clk);
        bus_addr  = a;
        bus_rd    = 1'b1;
        tmr_rdata = ~a[7:0];
        #1;
        h   = in_win(a);
        off = a[2:0];
        chk("R4 read tmr_sel", 32'(tmr_sel),
            (h && off >= 4 && off <= 6) ? 32'(3'b001 << (off - 3'd4)) : 32'd0);
        chk("R4 read tmr_rd", 32'(tmr_rd), 32'(h && off >= 4 && off <= 6));
        chk("R5 R6 read no write strobes", 32'({tmr_wr, tmr_ctl}), 32'd0);
        if (!h)            exp_d = 8'h00;
        else if (off < 4)  exp_d = exp_in[off*8 +: 8];
        else if (off == 7) exp_d = 8'hFF;
        else               exp_d = ~a[7:0];
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        chk("R1 rvalid", 32'(bus_rvalid), 32'(h));
        if (!h)            chk("R6 miss rdata", 32'(bus_rdata), 32'(exp_d));
        else if (off < 4)  chk(dio_tag, 32'(bus_rdata), 32'(exp_d));
        else if (off == 7) chk("R5 ctl read", 32'(bus_rdata), 32'(exp_d));
        else               chk("R4 counter read data", 32'(bus_rdata), 32'(exp_d));
    endtask

    task automatic do_write(input logic [9:0] a, input logic [7:0] d);
        bit h;
        logic [2:0] off;
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = 1'b1;
        bus_wdata = d;
        #1;
        h   = in_win(a);
        off = a[2:0];
        chk("R4 write tmr_sel", 32'(tmr_sel),
            (h && off >= 4 && off <= 6) ? 32'(3'b001 << (off - 3'd4)) : 32'd0);
        chk("R4 R5 R6 write tmr_wr", 32'(tmr_wr), 32'(h && off >= 4));
        chk("R5 write tmr_ctl", 32'(tmr_ctl), 32'(h && off == 7));
        chk("R6 write no tmr_rd", 32'(tmr_rd), 32'd0);
        chk("R4 tmr_wdata", 32'(tmr_wdata), 32'(d));
        if (h && off < 4) dm[off*8 +: 8] = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R2 dout", dout, dm);
    endtask

    task automatic read_all(input string tag);
        for (int k = 0; k < 4; k++) do_read({1'b1, cfg_base, 3'(k)}, tag);
    endtask

    initial begin
        logic [5:0] bases [5];
        bases = '{6'h00, 6'h01, 6'h15, 6'h2A, 6'h3F};
        din = 32'hC3A5_1E69;
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset dout", dout, 32'd0);
        chk("R9 reset rvalid", 32'(bus_rvalid), 32'd0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        exp_in = din;
        cfg_base = 6'h3F;
        read_all("R9 strobes high after reset");

        for (int bi = 0; bi < 5; bi++) begin
            cfg_base = bases[bi];
            for (int a = 0; a < 1024; a++) do_read(10'(a), "R3 input byte");
        end

        dm = '0;
        cfg_base = 6'h2A;
        for (int a = 0; a < 1024; a++) do_write(10'(a), 8'(a) ^ 8'h5A);
        cfg_base = 6'h00;
        for (int a = 0; a < 1024; a++) do_write(10'(a), 8'(a) ^ 8'hA7);

        cfg_base = 6'h2A;
        din = 32'h1111_2222; din_strobe = 2'b11;
        repeat (6) @(negedge clk);
        exp_in = din; read_all("R7 transparent");
        din_strobe = 2'b10;
        repeat (6) @(negedge clk);
        din = 32'h3333_4444;
        repeat (6) @(negedge clk);
        exp_in = 32'h3333_2222; read_all("R8 half0 frozen");
        din_strobe = 2'b11;
        repeat (6) @(negedge clk);
        exp_in = 32'h3333_4444; read_all("R7 half0 released");
        din_strobe = 2'b01;
        repeat (6) @(negedge clk);
        din = 32'h5555_6666;
        repeat (6) @(negedge clk);
        exp_in = 32'h3333_6666; read_all("R8 half1 frozen");
        din_strobe = 2'b00;
        repeat (6) @(negedge clk);
        din = 32'h7777_8888;
        repeat (6) @(negedge clk);
        exp_in = 32'h3333_6666; read_all("R8 both frozen");
        din_strobe = 2'b11;
        repeat (6) @(negedge clk);
        exp_in = 32'h7777_8888; read_all("R7 both released");

        chk("R2 dout before reset nonzero", 32'(dout != 0), 32'd1);
        rst_n = 1'b0;
        #1;
        chk("R9 dout cleared", dout, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule